// File: doc/BRIEF.md
# Keyed Write-Protect Gate

This block sits in front of the write port of a byte-wide nonvolatile memory model. It decides which write strobes reach the array. Every accepted write strobe is compared against two key sequences. Each sequence is a chain of address/data pairs. One sequence switches a protection flag on and the other switches it off. While the flag is set, a data write is let through only when the switch-on key came first in the same load session. In that case the key works as a one-time unlock. Key writes never reach the array.

Writes that are no more than `GAP_LIMIT` cycles apart form one load session. When a session closes, the block pulses a start request for the program timer and holds a busy flag for `TWC_CYCLES` cycles. It does this when the session granted data, held a blocked write, or completed a key. A session that held only blocked writes runs a dummy program cycle: nothing is stored, and the busy period is flagged as a polling window. Protection changes take effect only at the end of the program cycle that follows the key. The protection flag is loaded at reset from an input, so that a retained value can survive a power cycle. The factory value is 0.

Top module: `swp_guard`

## Requirements
- R1: While `rst` is high, `wr_grant`, `tmr_start`, `prog_busy` and `poll_busy` are 0, and `prot_on` takes the value of `prot_keep`.
- R2: When unprotected, a write strobe (`wr_en`=1 in a cycle with `prog_busy`=0) that is not a key step gives `wr_grant`=1 in the next cycle.
- R3: A write that matches the next key step is never granted. The steps are: data AA at address 5555, then 55 at 2AAA, then either A0 at 5555 (switch-on), or 80 at 5555 followed by AA at 5555, 55 at 2AAA and 20 at 5555 (switch-off). Values are hex.
- R4: A write that does not match the expected next step returns the key tracker to its start state. That write is treated as data.
- R5: `prot_on` changes only in the cycle where `prog_busy` falls. After a switch-on key it rises exactly `TWC_CYCLES` cycles after `tmr_start`.
- R6: While protected, a data write without the unlock prefix is not granted and leaves `prot_on` unchanged. If the session held only such writes, `poll_busy` is 1 for the whole program cycle.
- R7: While protected, data writes that follow a complete switch-on key in the same session are granted.
- R8: The six-step switch-off key clears `prot_on` at the end of the following program cycle. Until then, data writes stay blocked.
- R9: A write more than `GAP_LIMIT` cycles after the previous one starts a new session and resets the key tracker.
- R10: Write strobes while `prog_busy`=1 are ignored: they are not granted and they do not advance the key tracker.
- R11: `tmr_start` is a one-cycle pulse exactly `GAP_LIMIT` cycles after the last write of a session. It fires only if that session granted a write, blocked a write, or completed a key.
- R12: `prog_busy` rises together with `tmr_start` and stays high for exactly `TWC_CYCLES` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_keep | input | 1 | Retained protection value loaded during reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_grant | output | 1 | Write may be stored into the array |
| tmr_start | output | 1 | Program timer start pulse |
| prot_on | output | 1 | Protection flag |
| prog_busy | output | 1 | Program cycle in progress |
| poll_busy | output | 1 | Dummy program cycle in progress (reads act as polling) |

## Verification
The assertions assume three things about the inputs: each write is a single-cycle strobe that is stable across the clock edge, `prot_keep` is steady for the last cycles of reset, and `GAP_LIMIT` and `TWC_CYCLES` are at least 1. The bench drives every input on the falling edge and holds `prot_keep` for several cycles around each reset. It biases random addresses and data toward the key values and mixes inter-write gaps both inside and beyond the session limit, so that key sequences get completed, aborted and split across sessions.

// File: rtl/swp_pkg.sv
package swp_pkg;

  typedef enum logic [2:0] {
    K_IDLE,
    K_LEAD,
    K_SECOND,
    K_ERASE,
    K_ERASE_LEAD,
    K_ERASE_SECOND
  } key_st_t;

  typedef enum logic [1:0] {
    P_NONE,
    P_SET,
    P_CLR
  } pend_t;

endpackage

// File: rtl/swp_key_fsm.sv
module swp_key_fsm
  import swp_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8,
  parameter logic [AW-1:0] KEY_ADDR_A = AW'(15'h5555),
  parameter logic [AW-1:0] KEY_ADDR_B = AW'(15'h2AAA),
  parameter logic [DW-1:0] KEY_D_LEAD = DW'(8'hAA),
  parameter logic [DW-1:0] KEY_D_SECOND = DW'(8'h55),
  parameter logic [DW-1:0] KEY_D_EN = DW'(8'hA0),
  parameter logic [DW-1:0] KEY_D_ERASE = DW'(8'h80),
  parameter logic [DW-1:0] KEY_D_DIS = DW'(8'h20)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_act,
  input  logic          clr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          hit,
  output logic          en_done,
  output logic          dis_done
);

  key_st_t st_q, st_nxt;
  logic at_a, at_b;

  assign at_a = (addr == KEY_ADDR_A);
  assign at_b = (addr == KEY_ADDR_B);

  always_comb begin
    hit      = 1'b0;
    en_done  = 1'b0;
    dis_done = 1'b0;
    st_nxt   = K_IDLE;
    case (st_q)
      K_IDLE: if (at_a && data == KEY_D_LEAD) begin
        hit = 1'b1; st_nxt = K_LEAD;
      end
      K_LEAD: if (at_b && data == KEY_D_SECOND) begin
        hit = 1'b1; st_nxt = K_SECOND;
      end
      K_SECOND: begin
        if (at_a && data == KEY_D_EN) begin
          hit = 1'b1; en_done = 1'b1; st_nxt = K_IDLE;
        end else if (at_a && data == KEY_D_ERASE) begin
          hit = 1'b1; st_nxt = K_ERASE;
        end
      end
      K_ERASE: if (at_a && data == KEY_D_LEAD) begin
        hit = 1'b1; st_nxt = K_ERASE_LEAD;
      end
      K_ERASE_LEAD: if (at_b && data == KEY_D_SECOND) begin
        hit = 1'b1; st_nxt = K_ERASE_SECOND;
      end
      K_ERASE_SECOND: if (at_a && data == KEY_D_DIS) begin
        hit = 1'b1; dis_done = 1'b1; st_nxt = K_IDLE;
      end
      default: st_nxt = K_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) st_q <= K_IDLE;
    else if (wr_act) st_q <= st_nxt;
  end

  // R4: a non-matching write leaves the tracker at its start state
  a_r4_miss_to_idle: assert property (@(posedge clk) disable iff (rst)
    (wr_act && !hit) |=> (st_q == K_IDLE));

  // R9: closing a session clears the tracker
  a_r9_clr_to_idle: assert property (@(posedge clk) disable iff (rst)
    clr |=> (st_q == K_IDLE));

endmodule

// File: rtl/swp_window.sv
module swp_window #(
  parameter int GAP_LIMIT = 7500
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_act,
  output logic sess_act,
  output logic sess_end
);

  localparam int GW = $clog2(GAP_LIMIT + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_LIMIT - 1);

  logic [GW-1:0] gap_q;

  assign sess_end = sess_act && !wr_act && (gap_q == GAP_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sess_act <= 1'b0;
      gap_q    <= '0;
    end else if (wr_act) begin
      sess_act <= 1'b1;
      gap_q    <= '0;
    end else if (sess_end) begin
      sess_act <= 1'b0;
      gap_q    <= '0;
    end else if (sess_act) begin
      gap_q    <= gap_q + 1'b1;
    end
  end

  // R9: the idle gap inside a session never passes the limit
  a_r9_gap_bound: assert property (@(posedge clk) disable iff (rst)
    sess_act |-> (gap_q < GAP_LAST + 1'b1 || GAP_LIMIT == 1));

endmodule

// File: rtl/swp_prog_timer.sv
module swp_prog_timer #(
  parameter int TWC_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int TW = $clog2(TWC_CYCLES + 1);
  localparam logic [TW-1:0] TWC_LAST = TW'(TWC_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  assign done = busy && (cnt_q == TWC_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (done) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R12: a start request only arrives while the timer is idle
  a_r12_start_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R12: the count stays inside the program window
  a_r12_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q <= TWC_LAST));

endmodule

// File: rtl/swp_guard.sv
module swp_guard
  import swp_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8,
  parameter int GAP_LIMIT = 7500,
  parameter int TWC_CYCLES = 500000,
  parameter logic [AW-1:0] KEY_ADDR_A = AW'(15'h5555),
  parameter logic [AW-1:0] KEY_ADDR_B = AW'(15'h2AAA),
  parameter logic [DW-1:0] KEY_D_LEAD = DW'(8'hAA),
  parameter logic [DW-1:0] KEY_D_SECOND = DW'(8'h55),
  parameter logic [DW-1:0] KEY_D_EN = DW'(8'hA0),
  parameter logic [DW-1:0] KEY_D_ERASE = DW'(8'h80),
  parameter logic [DW-1:0] KEY_D_DIS = DW'(8'h20)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prot_keep,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_grant,
  output logic          tmr_start,
  output logic          prot_on,
  output logic          prog_busy,
  output logic          poll_busy
);

  logic  wr_act, key_hit, en_done, dis_done;
  logic  sess_act, sess_end, start, tdone, allow;
  logic  unlock_q, sgrant_q, sblock_q;
  pend_t pend_q;

  assign wr_act = wr_en && !prog_busy;
  assign allow  = !prot_on || unlock_q;
  assign start  = sess_end && (sgrant_q || sblock_q || pend_q != P_NONE);

  swp_key_fsm #(
    .AW(AW), .DW(DW),
    .KEY_ADDR_A(KEY_ADDR_A), .KEY_ADDR_B(KEY_ADDR_B),
    .KEY_D_LEAD(KEY_D_LEAD), .KEY_D_SECOND(KEY_D_SECOND),
    .KEY_D_EN(KEY_D_EN), .KEY_D_ERASE(KEY_D_ERASE), .KEY_D_DIS(KEY_D_DIS)
  ) u_keys (
    .clk(clk), .rst(rst), .wr_act(wr_act), .clr(sess_end),
    .addr(wr_addr), .data(wr_data),
    .hit(key_hit), .en_done(en_done), .dis_done(dis_done)
  );

  swp_window #(.GAP_LIMIT(GAP_LIMIT)) u_window (
    .clk(clk), .rst(rst), .wr_act(wr_act),
    .sess_act(sess_act), .sess_end(sess_end)
  );

  swp_prog_timer #(.TWC_CYCLES(TWC_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(start),
    .busy(prog_busy), .done(tdone)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_on   <= prot_keep;
      unlock_q  <= 1'b0;
      sgrant_q  <= 1'b0;
      sblock_q  <= 1'b0;
      pend_q    <= P_NONE;
      wr_grant  <= 1'b0;
      tmr_start <= 1'b0;
      poll_busy <= 1'b0;
    end else begin
      wr_grant  <= wr_act && !key_hit && allow;
      tmr_start <= start;
      if (wr_act) begin
        if (en_done) begin
          unlock_q <= 1'b1;
          pend_q   <= P_SET;
        end
        if (dis_done) pend_q <= P_CLR;
        if (!key_hit) begin
          if (allow) sgrant_q <= 1'b1;
          else       sblock_q <= 1'b1;
        end
      end
      if (sess_end) begin
        unlock_q  <= 1'b0;
        sgrant_q  <= 1'b0;
        sblock_q  <= 1'b0;
        poll_busy <= start && sblock_q && !sgrant_q && (pend_q == P_NONE);
      end
      if (tdone) begin
        poll_busy <= 1'b0;
        if (pend_q == P_SET) prot_on <= 1'b1;
        else if (pend_q == P_CLR) prot_on <= 1'b0;
        pend_q <= P_NONE;
      end
    end
  end

  // R11: the timer request lasts one cycle
  a_r11_start_single: assert property (@(posedge clk) disable iff (rst)
    tmr_start |=> !tmr_start);

  // R12: busy is raised in the cycle of the start pulse
  a_r12_start_busy: assert property (@(posedge clk) disable iff (rst)
    tmr_start |-> prog_busy);

  // R10: a strobe during a program cycle is never granted
  a_r10_busy_no_grant: assert property (@(posedge clk) disable iff (rst)
    prog_busy |=> !wr_grant);

  // R3: key steps never reach the array
  a_r3_key_not_granted: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !prog_busy && key_hit) |=> !wr_grant);

  // R6: the polling window lies inside a program cycle
  a_r6_poll_inside_busy: assert property (@(posedge clk) disable iff (rst)
    poll_busy |-> prog_busy);

  // R5: protection moves only when a program cycle ends
  a_r5_prot_at_end: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && prot_on != $past(prot_on)) |-> ($past(prog_busy) && !prog_busy));

  // R9: no load session is open during a program cycle
  a_r9_no_session_busy: assert property (@(posedge clk) disable iff (rst)
    prog_busy |-> !sess_act);

endmodule

// File: tb/test_swp_guard.sv
module test_swp_guard;

  localparam int AW = 17;
  localparam int DW = 8;
  localparam int GAP = 8;
  localparam int TWC = 20;
  localparam logic [AW-1:0] KA = 17'h05555;
  localparam logic [AW-1:0] KB = 17'h02AAA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prot_keep = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_grant, tmr_start, prot_on, prog_busy, poll_busy;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  swp_guard #(.AW(AW), .DW(DW), .GAP_LIMIT(GAP), .TWC_CYCLES(TWC)) i_swp_guard (
    .clk(clk), .rst(rst), .prot_keep(prot_keep),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_grant(wr_grant), .tmr_start(tmr_start), .prot_on(prot_on),
    .prog_busy(prog_busy), .poll_busy(poll_busy)
  );

  // expected-behaviour model built from the requirements
  int m_st = 0, m_pend = 0, m_gcnt = 0, m_bcnt = 0;
  bit m_prot = 0, m_unl = 0, m_sg = 0, m_sb = 0, m_grant = 0, m_ts = 0;
  bit m_poll = 0, m_busy = 0, m_sact = 0;

  function automatic int key_next(int st, logic [AW-1:0] a, logic [DW-1:0] d,
                                  output bit hit, output bit en, output bit dis);
    int n = 0;
    hit = 0; en = 0; dis = 0;
    case (st)
      0: if (a == KA && d == 8'hAA) begin hit = 1; n = 1; end
      1: if (a == KB && d == 8'h55) begin hit = 1; n = 2; end
      2: if (a == KA && d == 8'hA0) begin hit = 1; en = 1; n = 0; end
         else if (a == KA && d == 8'h80) begin hit = 1; n = 3; end
      3: if (a == KA && d == 8'hAA) begin hit = 1; n = 4; end
      4: if (a == KB && d == 8'h55) begin hit = 1; n = 5; end
      5: if (a == KA && d == 8'h20) begin hit = 1; dis = 1; n = 0; end
      default: n = 0;
    endcase
    return n;
  endfunction

  always @(posedge clk) begin
    bit act, allow, hit, en, dis, send, start, tdone;
    int nst;
    if (rst) begin
      m_prot = prot_keep; m_st = 0; m_pend = 0; m_gcnt = 0; m_bcnt = 0;
      m_unl = 0; m_sg = 0; m_sb = 0; m_grant = 0; m_ts = 0; m_poll = 0;
      m_busy = 0; m_sact = 0;
    end else begin
      act   = wr_en && !m_busy;
      allow = !m_prot || m_unl;
      nst   = key_next(m_st, wr_addr, wr_data, hit, en, dis);
      send  = m_sact && !act && (m_gcnt == GAP - 1);
      start = send && (m_sg || m_sb || m_pend != 0);
      tdone = m_busy && (m_bcnt == TWC - 1);
      m_grant = act && !hit && allow;
      m_ts    = start;
      if (act) begin
        if (en) begin m_unl = 1; m_pend = 1; end
        if (dis) m_pend = 2;
        if (!hit) begin
          if (allow) m_sg = 1; else m_sb = 1;
        end
        m_st = hit ? nst : 0;
        m_sact = 1; m_gcnt = 0;
      end else if (send) begin
        m_poll = start && m_sb && !m_sg && m_pend == 0;
        m_sact = 0; m_gcnt = 0; m_st = 0; m_unl = 0; m_sg = 0; m_sb = 0;
      end else if (m_sact) begin
        m_gcnt++;
      end
      if (start) begin
        m_busy = 1; m_bcnt = 0;
      end else if (tdone) begin
        m_busy = 0; m_bcnt = 0; m_poll = 0;
        if (m_pend == 1) m_prot = 1;
        else if (m_pend == 2) m_prot = 0;
        m_pend = 0;
      end else if (m_busy) begin
        m_bcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(wr_grant == m_grant, "R2", "wr_grant", wr_grant, m_grant);
      chk(tmr_start == m_ts, "R11", "tmr_start", tmr_start, m_ts);
      chk(prot_on == m_prot, "R5", "prot_on", prot_on, m_prot);
      chk(prog_busy == m_busy, "R12", "prog_busy", prog_busy, m_busy);
      chk(poll_busy == m_poll, "R6", "poll_busy", poll_busy, m_poll);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle();
    idle(GAP + TWC + 2);
  endtask

  task automatic do_reset(input bit keep);
    rst = 1'b1; prot_keep = keep;
    idle(3);
    chk(prot_on == keep && !wr_grant && !tmr_start && !prog_busy && !poll_busy,
        "R1", "reset state (prot_on)", prot_on, keep);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic key_on();
    wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'hA0);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    do_reset(1'b0);

    // R2, R11, R10, R12
    wr(17'h00100, 8'h3C);
    chk(wr_grant == 1, "R2", "plain write grant", wr_grant, 1);
    idle(7);
    chk(tmr_start == 0, "R11", "no start before gap", tmr_start, 0);
    idle(1);
    chk(tmr_start == 1 && prog_busy == 1, "R11", "start at gap end", tmr_start, 1);
    wr(KA, 8'hAA);
    chk(wr_grant == 0, "R10", "write in busy", wr_grant, 0);
    wr(KB, 8'h55);
    idle(17);
    chk(prog_busy == 1, "R12", "busy before end", prog_busy, 1);
    idle(1);
    chk(prog_busy == 0, "R12", "busy after TWC", prog_busy, 0);
    wr(KA, 8'hA0);
    chk(wr_grant == 1, "R10", "key not advanced in busy", wr_grant, 1);
    settle();
    chk(prot_on == 0, "R10", "no protection from ignored key", prot_on, 0);

    // R3, R5: switch-on key
    wr(KA, 8'hAA);
    chk(wr_grant == 0, "R3", "step1 grant", wr_grant, 0);
    wr(KB, 8'h55);
    chk(wr_grant == 0, "R3", "step2 grant", wr_grant, 0);
    wr(KA, 8'hA0);
    chk(wr_grant == 0, "R3", "step3 grant", wr_grant, 0);
    idle(8);
    chk(tmr_start == 1, "R11", "start after key", tmr_start, 1);
    idle(19);
    chk(prot_on == 0, "R5", "prot before end", prot_on, 0);
    idle(1);
    chk(prot_on == 1, "R5", "prot after TWC", prot_on, 1);
    settle();

    // R6: blocked write runs a dummy cycle
    wr(17'h00200, 8'h11);
    chk(wr_grant == 0, "R6", "blocked write", wr_grant, 0);
    idle(8);
    chk(poll_busy == 1, "R6", "poll window", poll_busy, 1);
    idle(20);
    chk(poll_busy == 0 && prot_on == 1, "R6", "prot kept", prot_on, 1);
    settle();

    // R7: unlocked page
    key_on();
    wr(17'h00300, 8'h22);
    chk(wr_grant == 1, "R7", "unlocked write 1", wr_grant, 1);
    wr(17'h00301, 8'h23);
    chk(wr_grant == 1, "R7", "unlocked write 2", wr_grant, 1);
    idle(8);
    chk(poll_busy == 0 && prog_busy == 1, "R7", "real program cycle", poll_busy, 0);
    settle();

    // R4: aborted prefix
    wr(KA, 8'hAA);
    wr(KB, 8'h56);
    chk(wr_grant == 0, "R4", "mismatch treated as blocked data", wr_grant, 0);
    wr(KA, 8'hA0);
    chk(wr_grant == 0, "R4", "A0 after abort blocked", wr_grant, 0);
    wr(17'h00400, 8'h44);
    chk(wr_grant == 0, "R4", "no unlock after abort", wr_grant, 0);
    settle();

    // R9: key split by a long gap
    wr(KA, 8'hAA);
    idle(GAP + 1);
    chk(tmr_start == 0 && prog_busy == 0, "R11", "bare prefix starts nothing", prog_busy, 0);
    wr(KB, 8'h55); wr(KA, 8'hA0);
    wr(17'h00410, 8'h45);
    chk(wr_grant == 0, "R9", "split key does not unlock", wr_grant, 0);
    settle();

    // R8: switch-off key
    wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'h80);
    wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'h20);
    chk(wr_grant == 0, "R8", "last off step grant", wr_grant, 0);
    wr(17'h00500, 8'h33);
    chk(wr_grant == 0, "R8", "still blocked", wr_grant, 0);
    idle(8);
    chk(poll_busy == 0, "R8", "off key is not a dummy cycle", poll_busy, 0);
    idle(20);
    chk(prot_on == 0, "R8", "prot cleared", prot_on, 0);
    wr(17'h00501, 8'h34);
    chk(wr_grant == 1, "R8", "grant after clear", wr_grant, 1);
    settle();

    // R1: retained value across reset
    do_reset(1'b1);
    chk(prot_on == 1, "R1", "retained prot", prot_on, 1);
    do_reset(1'b0);

    // random phase
    for (int it = 0; it < 1500; it++) begin
      int r = $urandom_range(0, 99);
      if (r < 2) begin
        do_reset(1'($urandom_range(0, 1)));
      end else if (r < 6) begin
        key_on();
      end else if (r < 9) begin
        wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'h80);
        wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'h20);
      end else if (r < 70) begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int s = $urandom_range(0, 2);
        int t = $urandom_range(0, 5);
        a = (s == 0) ? KA : (s == 1) ? KB : AW'($urandom);
        case (t)
          0: d = 8'hAA; 1: d = 8'h55; 2: d = 8'hA0;
          3: d = 8'h80; 4: d = 8'h20; default: d = DW'($urandom);
        endcase
        wr(a, d);
      end
      idle($urandom_range(0, 11));
    end
    settle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not end");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule